// File: doc/BRIEF.md
# Direct-Mapped Load Cache with Software-Chosen Set Index

This block is a direct-mapped data cache that serves loads only. Every load carries two addresses. The real address is the one that exists in memory. It supplies the tag that is compared, the word within the line, and the address of any line fetched from memory. The mapping address is used for one thing only: it selects the cache set. Software can set it equal to the real address, and the cache then behaves as an ordinary direct-mapped cache. Software can also set it to the real address plus one line length. This moves a stream whose base collides with another array's base into the neighbouring set. The mapping address never leaves the block, so it does not have to be a valid memory address.

A hit answers in the cycle after the request is accepted, whichever address chose the set. On a miss the request port stops accepting requests. The block asks memory for the whole line at the real line address, writes that line into the set picked by the mapping address, and then returns the word. Each tag entry keeps the complete real line address, so a line stored outside its natural set cannot be mistaken for another line. The block also has a separate combinational helper that tells software whether two base addresses need remapping. It raises a flag when their distance, taken modulo the cache size, is less than one line.

Top module: `dmc_twin_cache`

## Requirements
- R1: A load that hits returns its word with rsp_valid high in the cycle after acceptance, and adds no further cycle when the mapping address differs from the real address.
- R2: The set is selected by mapping-address bits [13:5]. The word within the line is selected by real-address bits [4:2]. A line is 32 bytes, and word k of the line sits at bits [32k+31:32k] of mem_rsp_data.
- R3: A tag entry holds real-address bits [31:5]. A lookup hits only if the stored value equals the request's real line address and the entry is valid.
- R4: On a miss, req_ready stays low until the line has arrived. The block raises mem_req_valid with mem_req_addr equal to the real address with bits [4:0] cleared. The mapping address is never used for this.
- R5: After a refill, the line is held in the set chosen by the mapping address, and a repeat of the same request hits. A line in any other set is left untouched.
- R6: If the real and mapping addresses differ in bits [4:0], the load is answered in the next cycle with rsp_err=1 and rsp_data=0. It causes no memory request and changes no cache state.
- R7: Reset clears every valid bit, so the first load after reset misses.
- R8: While inv_all is high, req_ready is low. One cycle of inv_all clears every valid bit.
- R9: conf_flag is 1 exactly when |conf_base_a - conf_base_b| mod 16384 is less than 32.
- R10: mem_req_valid stays high with mem_req_addr unchanged until mem_req_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| inv_all | input | 1 | Clears every valid bit |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a load |
| req_real_addr | input | 32 | Real byte address (tag, word select, refill) |
| req_map_addr | input | 32 | Mapping byte address (set select only) |
| rsp_valid | output | 1 | Load answer present |
| rsp_data | output | 32 | Loaded word |
| rsp_err | output | 1 | Line offsets of the two addresses disagreed |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 32 | Real line address to fetch |
| mem_rsp_valid | input | 1 | Line data present |
| mem_rsp_data | input | 256 | Full line, word 0 in the low bits |
| conf_base_a | input | 32 | First base address for the conflict test |
| conf_base_b | input | 32 | Second base address for the conflict test |
| conf_flag | output | 1 | The two bases collide and need remapping |

## Verification
The hardest case to reach is a line that sits outside its natural set while another address maps naturally to that same set and shares the line's upper address bits. Only this case shows whether the tag holds the whole real line address or just the bits above the index. The stimulus table reaches it in three steps. It first fills a set with a remapped line (real 0x5008 mapped at 0x5028). It then loads 0x5020 with its own address, which must miss. Finally it loads the real 0x5000 line through the 0x5020 mapping, which must miss as well. The memory model builds every line from the fetched address, so any refill that used the mapping address would come back with the wrong data.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_conflict_detect.sv
module dmc_conflict_detect #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_BYTES  = 32
) (
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  output logic              collide
);
  localparam int CB_W = $clog2(CACHE_BYTES);
  localparam logic [CB_W-1:0] LINE_LIM = CB_W'(LINE_BYTES);

  logic          a_ge_b;
  logic [CB_W-1:0] d_ab, d_ba, dist_mod;

  // low bits of a difference depend only on low bits of the operands
  always_comb begin
    a_ge_b   = (base_a >= base_b);
    d_ab     = base_a[CB_W-1:0] - base_b[CB_W-1:0];
    d_ba     = base_b[CB_W-1:0] - base_a[CB_W-1:0];
    dist_mod = a_ge_b ? d_ab : d_ba;
    collide  = (dist_mod < LINE_LIM);
  end
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int SETS  = 512,
  parameter int IDX_W = 9,
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  valid_q, valid_d;

  always_comb begin
    valid_d = valid_q;
    if (inv_all) begin
      valid_d = '0;
    end else if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_tag   = tag_mem[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  AST_INV_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0)) else $error("invalidate left a line valid"); // R8
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int SETS   = 512,
  parameter int IDX_W  = 9,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) line_mem[wr_idx] <= wr_line;
  end

  assign rd_line = line_mem[rd_idx];
endmodule

// File: rtl/dmc_twin_cache.sv
module dmc_twin_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int LINE_BYTES  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inv_all,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_real_addr,
  input  logic [ADDR_W-1:0]         req_map_addr,
  output logic                      rsp_valid,
  output logic [WORD_W-1:0]         rsp_data,
  output logic                      rsp_err,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [ADDR_W-1:0]         mem_req_addr,
  input  logic                      mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]   mem_rsp_data,
  input  logic [ADDR_W-1:0]         conf_base_a,
  input  logic [ADDR_W-1:0]         conf_base_b,
  output logic                      conf_flag
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SETS   = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WORDS  = LINE_BYTES / (WORD_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BOFF_W = $clog2(WORD_W / 8);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  dmc_state_e         state_q, state_d;
  logic [TAG_W-1:0]   hold_tag_q, hold_tag_d;
  logic [IDX_W-1:0]   hold_idx_q, hold_idx_d;
  logic [WSEL_W-1:0]  hold_wsel_q, hold_wsel_d;
  logic               rsp_valid_q, rsp_valid_d;
  logic               rsp_err_q, rsp_err_d;
  logic [WORD_W-1:0]  rsp_data_q, rsp_data_d;

  logic               accept, off_mismatch, lookup_hit, fill;
  logic [IDX_W-1:0]   req_idx;
  logic [TAG_W-1:0]   req_tag, rd_tag;
  logic [WSEL_W-1:0]  req_wsel;
  logic               rd_valid;
  logic [LINE_W-1:0]  rd_line;
  logic [WORDS-1:0][WORD_W-1:0] rd_words, fill_words;
  logic               map_hi_unused;

  // set comes from the mapping address, tag and word from the real one
  assign req_idx       = req_map_addr[OFF_W +: IDX_W];
  assign req_tag       = req_real_addr[ADDR_W-1:OFF_W];
  assign req_wsel      = req_real_addr[OFF_W-1:BOFF_W];
  assign map_hi_unused = ^req_map_addr[ADDR_W-1:OFF_W+IDX_W];
  assign off_mismatch  = (req_real_addr[OFF_W-1:0] != req_map_addr[OFF_W-1:0]);

  assign req_ready  = (state_q == ST_IDLE) && !inv_all;
  assign accept     = req_valid && req_ready;
  assign lookup_hit = rd_valid && (rd_tag == req_tag);
  assign fill       = (state_q == ST_MWAIT) && mem_rsp_valid;
  assign rd_words   = rd_line;
  assign fill_words = mem_rsp_data;

  dmc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_ns), .inv_all(inv_all),
    .rd_idx(req_idx), .rd_tag(rd_tag), .rd_valid(rd_valid),
    .wr_en(fill), .wr_idx(hold_idx_q), .wr_tag(hold_tag_q)
  );

  dmc_line_store #(.SETS(SETS), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_lines (
    .clk(clk), .rd_idx(req_idx), .rd_line(rd_line),
    .wr_en(fill), .wr_idx(hold_idx_q), .wr_line(mem_rsp_data)
  );

  dmc_conflict_detect #(.ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES),
                        .LINE_BYTES(LINE_BYTES)) u_conf (
    .base_a(conf_base_a), .base_b(conf_base_b), .collide(conf_flag)
  );

  always_comb begin
    state_d     = state_q;
    hold_tag_d  = hold_tag_q;
    hold_idx_d  = hold_idx_q;
    hold_wsel_d = hold_wsel_q;
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_data_d  = '0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (off_mismatch) begin
            rsp_valid_d = 1'b1;
            rsp_err_d   = 1'b1;
          end else if (lookup_hit) begin
            rsp_valid_d = 1'b1;
            rsp_data_d  = rd_words[req_wsel];
          end else begin
            state_d     = ST_MREQ;
            hold_tag_d  = req_tag;
            hold_idx_d  = req_idx;
            hold_wsel_d = req_wsel;
          end
        end
      end
      ST_MREQ: begin
        if (mem_req_ready) state_d = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (mem_rsp_valid) begin
          state_d     = ST_IDLE;
          rsp_valid_d = 1'b1;
          rsp_data_d  = fill_words[hold_wsel_q];
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q     <= ST_IDLE;
      hold_tag_q  <= '0;
      hold_idx_q  <= '0;
      hold_wsel_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      hold_tag_q  <= hold_tag_d;
      hold_idx_q  <= hold_idx_d;
      hold_wsel_q <= hold_wsel_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_err       = rsp_err_q;
  assign rsp_data      = rsp_data_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = {hold_tag_q, {OFF_W{1'b0}}};

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_ns)
    (accept && !off_mismatch && lookup_hit) |=> (rsp_valid && !rsp_err && !mem_req_valid))
    else $error("hit not answered next cycle"); // R1
  AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rst_ns)
    (accept && !off_mismatch && !lookup_hit) |=> (mem_req_valid && !req_ready && !rsp_valid))
    else $error("miss did not start a fetch"); // R4
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
    else $error("fetch request dropped or changed"); // R10
  AST_ERR_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_ns)
    (accept && off_mismatch) |=> (rsp_err && rsp_valid && !mem_req_valid && rsp_data == '0))
    else $error("offset mismatch mishandled"); // R6
  AST_FETCH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req_valid |-> !req_ready) else $error("accepting during fetch"); // R4
  AST_INV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ns)
    inv_all |-> !req_ready) else $error("accepting during invalidate"); // R8
endmodule

// File: tb/dmc_twin_cache_test.sv
module dmc_twin_cache_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         inv_all;
  logic         req_valid;
  logic         req_ready;
  logic [31:0]  req_real_addr, req_map_addr;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic         rsp_err;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid;
  logic [255:0] mem_rsp_data;
  logic [31:0]  conf_base_a, conf_base_b;
  logic         conf_flag;

  int nchk = 0;
  int nerr = 0;
  int mem_cnt = 0;
  logic [31:0] last_mem_addr = '0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  dmc_twin_cache uut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_real_addr(req_real_addr), .req_map_addr(req_map_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .conf_base_a(conf_base_a), .conf_base_b(conf_base_b), .conf_flag(conf_flag)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [255:0] make_line(input logic [31:0] la);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = exp_word({la[31:5], k[2:0], 2'b00});
    return l;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory model: one cycle before ready, two cycles to data
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a0;
        a0 = mem_req_addr;
        check(!req_ready, "R4", "ready during fetch", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        check(mem_req_valid && mem_req_addr == a0, "R10", "fetch held", mem_req_addr, a0);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_cnt++;
        last_mem_addr = a0;
        @(negedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = make_line(a0);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic do_load(input logic [31:0] ra, input logic [31:0] ma,
                         input bit exp_hit, input bit exp_err, input string rq);
    int lat;
    int mc0;
    while (!req_ready) @(negedge clk);
    mc0 = mem_cnt;
    req_valid = 1'b1;
    req_real_addr = ra;
    req_map_addr  = ma;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (exp_err) begin
      check(rsp_valid && rsp_err && rsp_data == 32'd0 && lat == 1, rq, "error answer",
            rsp_data, 32'd0);
      check(mem_cnt == mc0, rq, "no fetch on error", mem_cnt, mc0);
    end else begin
      check(rsp_valid && !rsp_err && rsp_data == exp_word(ra), rq, "load data",
            rsp_data, exp_word(ra));
      if (exp_hit) begin
        check(lat == 1 && mem_cnt == mc0, rq, "hit latency", lat, 1);
      end else begin
        check(mem_cnt == mc0 + 1, rq, "miss fetch count", mem_cnt, mc0 + 1);
        check(last_mem_addr == {ra[31:5], 5'd0}, rq, "fetch real line address",
              last_mem_addr, {ra[31:5], 5'd0});
      end
    end
  endtask

  // real, map, expect hit, expect error
  localparam int NV = 11;
  localparam logic [65:0] VEC [NV] = '{
    {32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0},  // R7 empty after reset
    {32'h0000_1004, 32'h0000_1004, 1'b1, 1'b0},  // R1 R2 word 1
    {32'h0000_5000, 32'h0000_5000, 1'b0, 1'b0},  // same set, evicts
    {32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0},  // thrash
    {32'h0000_5008, 32'h0000_5028, 1'b0, 1'b0},  // R4 twin refill at real
    {32'h0000_1000, 32'h0000_1000, 1'b1, 1'b0},  // R5 natural set kept
    {32'h0000_500C, 32'h0000_502C, 1'b1, 1'b0},  // R1 twin hit
    {32'h0000_5020, 32'h0000_5020, 1'b0, 1'b0},  // R3 full tag
    {32'h0000_5000, 32'h0000_5020, 1'b0, 1'b0},  // R3 R5 replace
    {32'h0000_1004, 32'h0000_1008, 1'b0, 1'b1},  // R6 offset mismatch
    {32'h0000_1000, 32'h0000_1000, 1'b1, 1'b0}   // R6 state unchanged
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    inv_all = 1'b0;
    req_valid = 1'b0;
    req_real_addr = '0;
    req_map_addr = '0;
    conf_base_a = '0;
    conf_base_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req_valid, "R7", "reset state",
          {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][65:34], VEC[i][33:2], VEC[i][1], VEC[i][0], $sformatf("R2 vec%0d", i));
    end

    // R8: invalidate blocks requests and empties the cache
    inv_all = 1'b1;
    #1;
    check(!req_ready, "R8", "ready during invalidate", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    inv_all = 1'b0;
    do_load(32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0, "R8");
    do_load(32'h0000_101C, 32'h0000_101C, 1'b1, 1'b0, "R5");

    // R7: a second reset empties the cache
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_load(32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0, "R7");

    // R9: conflict flag
    conf_base_a = 32'h0000_1000; conf_base_b = 32'h0000_5000; #1;
    check(conf_flag == 1'b1, "R9", "distance 0 mod size", {31'd0, conf_flag}, 32'd1);
    conf_base_a = 32'h0000_0000; conf_base_b = 32'h0000_4010; #1;
    check(conf_flag == 1'b1, "R9", "distance 16", {31'd0, conf_flag}, 32'd1);
    conf_base_a = 32'h0000_0000; conf_base_b = 32'h0000_4020; #1;
    check(conf_flag == 1'b0, "R9", "distance 32", {31'd0, conf_flag}, 32'd0);
    conf_base_a = 32'h0000_4010; conf_base_b = 32'h0000_0000; #1;
    check(conf_flag == 1'b1, "R9", "reversed order", {31'd0, conf_flag}, 32'd1);
    conf_base_a = 32'h0000_0000; conf_base_b = 32'h0000_3FF0; #1;
    check(conf_flag == 1'b0, "R9", "distance near size", {31'd0, conf_flag}, 32'd0);

    done = 1;
    finish_run();
  end
endmodule